// File: doc/BRIEF.md
# Bus-Attached I/O Shell with Dual-Clock FIFOs

This block is the fixed frame that surrounds a user-defined I/O protocol engine. The processor reaches it through a small 32-bit register slave: a control word, a state word, a write-only transmit data port and a read-only receive data port. Outbound words enter a 256 x 32 transmit FIFO in the bus clock domain. Inbound words leave a 256 x 32 receive FIFO in the same domain. The far side of both FIFOs runs on an independent external interface clock. Each FIFO holds 1 KB.

In this build the protocol engine is a loopback stub. When enabled, the stub moves one word per external clock from the transmit FIFO into the receive FIFO. It also shows each moved word on a monitor stream port in the external domain. Pointers cross between the domains as Gray codes through two-flop synchronizers. The enable bit also reaches the external domain through a two-flop synchronizer, and the stub moves data only after that synchronized copy is set. An interrupt line combines a receive-not-empty source and a transmit-half-empty source, and each source has its own mask bit.

Top module: `rio_shell`

## Requirements
- R1: After reset the state word reads 0x0A (TX empty bit 1 and RX empty bit 3 set, all other bits clear), the control word reads 0 and `irq` is low.
- R2: The map is decoded on the full 4-bit address: 0x0 control, 0x4 state, 0x8 TX data (write-only, reads return 0) and 0xC RX data (read-only). Read data appears on `busRdata` one bus clock after the read strobe.
- R3: With control bit 0 (enable) set, words written to TX data come back from RX data in the order they were written. Each word also appears once on `extMonData`, with `extMonValid` high, in the same order.
- R4: While enable is clear, no word moves: `extMonValid` stays low and RX stays empty, and words written to TX stay queued.
- R5: TX full (state bit 0) is set when TX holds 256 words. A write to TX data while TX is full is dropped and sets the sticky overflow flag (state bit 4). Writing 0 to that bit leaves the flag set. Writing 1 to it clears the flag.
- R6: A read of RX data while RX is empty returns 0 and removes nothing.
- R7: Control bit 1 empties TX and control bit 2 empties RX. Each takes effect only when the same write leaves enable clear. Neither bit is stored: both read back as 0.
- R8: `irq` is high when control bit 3 is set and RX holds a word, or when control bit 4 is set and TX holds 128 words or fewer. `irq` is a registered output.
- R9: When RX reaches 256 words (state bit 2), the stub stops and the remaining words wait in TX. As RX is drained, the waiting words follow in order, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Internal bus clock |
| busRstN | input | 1 | Active-low reset, bus domain |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 4 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |
| extClk | input | 1 | External interface clock |
| extRstN | input | 1 | Active-low reset, external domain |
| extMonValid | output | 1 | A word moved through the stub this external cycle |
| extMonData | output | 32 | The word that moved |

## Verification
The loopback path is tested with three traffic shapes. A short burst checks ordering and the monitor port. A 300-word burst overfills RX, which tells correct backpressure apart from silent loss or reordering across the pointer wrap. A 257-word fill with the stub disabled shows whether the dropped word ever reaches the far side. The interrupt is tested with TX at exactly 128 and then 129 words, which separates an off-by-one in the half-empty threshold from a correct one. Flush and enable-off sequences show whether the state word follows FIFO contents rather than register history.

// File: rtl/rio_pkg.sv
package rio_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_STATE = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_TX    = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_RX    = 4'hC;

  // control word bit positions
  localparam int CB_EN     = 0;
  localparam int CB_TXFL   = 1;
  localparam int CB_RXFL   = 2;
  localparam int CB_IERX   = 3;
  localparam int CB_IETX   = 4;
  localparam int CB_OVFCLR = 4;

  typedef struct packed {
    logic enable;
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } rio_strobe_t;
endpackage

// File: rtl/rio_async_fifo.sv
module rio_async_fifo #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          wClk,
  input  logic          wRstN,
  input  logic          wEn,
  input  logic          wFlush,
  input  logic [DW-1:0] wData,
  output logic [AW:0]   wLevel,
  input  logic          rClk,
  input  logic          rRstN,
  input  logic          rEn,
  input  logic          rFlush,
  output logic [DW-1:0] rData,
  output logic [AW:0]   rLevel
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);
  localparam logic [AW:0] ONE = (AW+1)'(1);

  function automatic logic [AW:0] bin2gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] gray2bin(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [AW:0] wrBin, wrGray, wrNext;
  logic [AW:0] rdGrayS1, rdGrayS2, rdBinSync;
  logic        wFull, wDo;

  // read domain
  logic [AW:0] rdBin, rdGray, rdNext;
  logic [AW:0] wrGrayS1, wrGrayS2, wrBinSync;
  logic        rEmpty, rDo;

  always_comb begin
    rdBinSync = gray2bin(rdGrayS2);
    wLevel    = wrBin - rdBinSync;
    wFull     = (wLevel == FULL_LVL);
    wDo       = wEn && !wFull && !wFlush;
    if (wFlush)   wrNext = rdBinSync;
    else if (wDo) wrNext = wrBin + ONE;
    else          wrNext = wrBin;
  end

  always_ff @(posedge wClk or negedge wRstN) begin
    if (!wRstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
    end else begin
      wrBin    <= wrNext;
      wrGray   <= bin2gray(wrNext);
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
    end
  end

  always_ff @(posedge wClk) begin
    if (wDo) mem[wrBin[AW-1:0]] <= wData;
  end

  always_comb begin
    wrBinSync = gray2bin(wrGrayS2);
    rLevel    = wrBinSync - rdBin;
    rEmpty    = (rLevel == '0);
    rDo       = rEn && !rEmpty && !rFlush;
    if (rFlush)   rdNext = wrBinSync;
    else if (rDo) rdNext = rdBin + ONE;
    else          rdNext = rdBin;
    rData     = mem[rdBin[AW-1:0]];
  end

  always_ff @(posedge rClk or negedge rRstN) begin
    if (!rRstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      wrGrayS1 <= '0;
      wrGrayS2 <= '0;
    end else begin
      rdBin    <= rdNext;
      rdGray   <= bin2gray(rdNext);
      wrGrayS1 <= wrGray;
      wrGrayS2 <= wrGrayS1;
    end
  end

  // R9
  level_bound_chk: assert property (@(posedge wClk) disable iff (!wRstN)
    wLevel <= FULL_LVL);

  // R5
  full_drop_chk: assert property (@(posedge wClk) disable iff (!wRstN)
    (wEn && wFull && !wFlush) |=> $stable(wrBin));

  // R6
  empty_hold_chk: assert property (@(posedge rClk) disable iff (!rRstN)
    (rEn && rEmpty && !rFlush) |=> $stable(rdBin));
endmodule

// File: rtl/rio_ctrl.sv
module rio_ctrl
  import rio_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [4:0]        wrBits,
  input  logic              txFull,
  input  logic              txEmpty,
  input  logic              txHalf,
  input  logic              rxFull,
  input  logic              rxEmpty,
  input  logic [DW-1:0]     rxHead,
  output rio_strobe_t       strobe,
  output logic [DW-1:0]     busRdata,
  output logic              irq
);
  logic enQ, ieRxQ, ieTxQ, ovfQ, irqQ;
  logic [DW-1:0] rdataQ;
  logic wrCtrl, wrState, wrTx, rdRx;

  always_comb begin
    wrCtrl  = busWr && (busAddr == ADDR_CTRL);
    wrState = busWr && (busAddr == ADDR_STATE);
    wrTx    = busWr && (busAddr == ADDR_TX);
    rdRx    = busRd && (busAddr == ADDR_RX);

    strobe.enable  = enQ;
    strobe.txPush  = wrTx && !txFull;
    strobe.rxPop   = rdRx && !rxEmpty;
    strobe.txFlush = wrCtrl && wrBits[CB_TXFL] && !wrBits[CB_EN];
    strobe.rxFlush = wrCtrl && wrBits[CB_RXFL] && !wrBits[CB_EN];
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      enQ    <= 1'b0;
      ieRxQ  <= 1'b0;
      ieTxQ  <= 1'b0;
      ovfQ   <= 1'b0;
      irqQ   <= 1'b0;
      rdataQ <= '0;
    end else begin
      if (wrCtrl) begin
        enQ   <= wrBits[CB_EN];
        ieRxQ <= wrBits[CB_IERX];
        ieTxQ <= wrBits[CB_IETX];
      end
      if (wrTx && txFull)                  ovfQ <= 1'b1;
      else if (wrState && wrBits[CB_OVFCLR]) ovfQ <= 1'b0;

      irqQ <= (ieRxQ && !rxEmpty) || (ieTxQ && txHalf);

      if (busRd) begin
        unique case (busAddr)
          ADDR_CTRL:  rdataQ <= DW'({ieTxQ, ieRxQ, 2'b00, enQ});
          ADDR_STATE: rdataQ <= DW'({ovfQ, rxEmpty, rxFull, txEmpty, txFull});
          ADDR_RX:    rdataQ <= rxEmpty ? '0 : rxHead;
          default:    rdataQ <= '0;
        endcase
      end
    end
  end

  assign busRdata = rdataQ;
  assign irq      = irqQ;

  // R5
  ovf_set_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (busWr && busAddr == ADDR_TX && txFull) |=> busRdata == busRdata && ovfQ);

  // R5
  ovf_sticky_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (ovfQ && !(busWr && busAddr == ADDR_STATE && wrBits[CB_OVFCLR])) |=> ovfQ);

  // R6
  rx_empty_zero_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (busRd && busAddr == ADDR_RX && rxEmpty) |=> busRdata == '0);
endmodule

// File: rtl/rio_datapath.sv
module rio_datapath
  import rio_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          busClk,
  input  logic          busRstN,
  input  rio_strobe_t   strobe,
  input  logic [DW-1:0] txWData,
  output logic          txFull,
  output logic          txEmpty,
  output logic          txHalf,
  output logic          rxFull,
  output logic          rxEmpty,
  output logic [DW-1:0] rxHead,
  input  logic          extClk,
  input  logic          extRstN,
  output logic          extMonValid,
  output logic [DW-1:0] extMonData
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_LVL = (AW+1)'(DEPTH / 2);

  logic [AW:0]   txBusLvl, txExtLvl, rxExtLvl, rxBusLvl;
  logic [DW-1:0] txExtData;
  logic          enMeta, enSync, moveNow;
  logic          monValidQ;
  logic [DW-1:0] monDataQ;

  rio_async_fifo #(.AW(AW), .DW(DW)) u_txFifo (
    .wClk   (busClk),
    .wRstN  (busRstN),
    .wEn    (strobe.txPush),
    .wFlush (strobe.txFlush),
    .wData  (txWData),
    .wLevel (txBusLvl),
    .rClk   (extClk),
    .rRstN  (extRstN),
    .rEn    (moveNow),
    .rFlush (1'b0),
    .rData  (txExtData),
    .rLevel (txExtLvl)
  );

  rio_async_fifo #(.AW(AW), .DW(DW)) u_rxFifo (
    .wClk   (extClk),
    .wRstN  (extRstN),
    .wEn    (moveNow),
    .wFlush (1'b0),
    .wData  (txExtData),
    .wLevel (rxExtLvl),
    .rClk   (busClk),
    .rRstN  (busRstN),
    .rEn    (strobe.rxPop),
    .rFlush (strobe.rxFlush),
    .rData  (rxHead),
    .rLevel (rxBusLvl)
  );

  always_comb begin
    txFull  = (txBusLvl == FULL_LVL);
    txEmpty = (txBusLvl == '0);
    txHalf  = (txBusLvl <= HALF_LVL);
    rxFull  = (rxBusLvl == FULL_LVL);
    rxEmpty = (rxBusLvl == '0);
    moveNow = enSync && (txExtLvl != '0) && (rxExtLvl != FULL_LVL);
  end

  // external-domain stub: enable synchronizer and monitor stream
  always_ff @(posedge extClk or negedge extRstN) begin
    if (!extRstN) begin
      enMeta    <= 1'b0;
      enSync    <= 1'b0;
      monValidQ <= 1'b0;
      monDataQ  <= '0;
    end else begin
      enMeta    <= strobe.enable;
      enSync    <= enMeta;
      monValidQ <= moveNow;
      if (moveNow) monDataQ <= txExtData;
    end
  end

  assign extMonValid = monValidQ;
  assign extMonData  = monDataQ;

  // R4
  stub_idle_chk: assert property (@(posedge extClk) disable iff (!extRstN)
    !enSync |=> !extMonValid);

  // R9
  rx_no_overrun_chk: assert property (@(posedge extClk) disable iff (!extRstN)
    (rxExtLvl == FULL_LVL) |=> !extMonValid);
endmodule

// File: rtl/rio_shell.sv
module rio_shell
  import rio_pkg::*;
#(
  parameter int FIFO_AW = 8,
  parameter int DATA_W  = 32
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  input  logic              extClk,
  input  logic              extRstN,
  output logic              extMonValid,
  output logic [DATA_W-1:0] extMonData
);
  rio_strobe_t       strobe;
  logic              txFull, txEmpty, txHalf, rxFull, rxEmpty;
  logic [DATA_W-1:0] rxHead;

  rio_ctrl #(.DW(DATA_W)) u_ctrl (
    .busClk   (busClk),
    .busRstN  (busRstN),
    .busWr    (busWr),
    .busRd    (busRd),
    .busAddr  (busAddr),
    .wrBits   (busWdata[4:0]),
    .txFull   (txFull),
    .txEmpty  (txEmpty),
    .txHalf   (txHalf),
    .rxFull   (rxFull),
    .rxEmpty  (rxEmpty),
    .rxHead   (rxHead),
    .strobe   (strobe),
    .busRdata (busRdata),
    .irq      (irq)
  );

  rio_datapath #(.AW(FIFO_AW), .DW(DATA_W)) u_dp (
    .busClk      (busClk),
    .busRstN     (busRstN),
    .strobe      (strobe),
    .txWData     (busWdata),
    .txFull      (txFull),
    .txEmpty     (txEmpty),
    .txHalf      (txHalf),
    .rxFull      (rxFull),
    .rxEmpty     (rxEmpty),
    .rxHead      (rxHead),
    .extClk      (extClk),
    .extRstN     (extRstN),
    .extMonValid (extMonValid),
    .extMonData  (extMonData)
  );
endmodule

// File: tb/sim_rio_shell.sv
module sim_rio_shell;
  localparam int CLK_PERIOD = 10;
  localparam int EXT_PERIOD = 14;
  localparam int WATCHDOG   = 150000;

  logic        busClk = 1'b0, extClk = 1'b0;
  logic        busRstN = 1'b0, extRstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq, extMonValid;
  logic [31:0] extMonData;

  int vectors = 0, fails = 0, cycles = 0, monCount = 0;
  logic [31:0] monLog [0:1023];
  bit done = 0;

  rio_shell u0 (
    .busClk(busClk), .busRstN(busRstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .extClk(extClk), .extRstN(extRstN),
    .extMonValid(extMonValid), .extMonData(extMonData)
  );

  always #(CLK_PERIOD/2) busClk = ~busClk;
  always #(EXT_PERIOD/2) extClk = ~extClk;

  always @(negedge extClk) begin
    if (extMonValid) begin
      monLog[monCount[9:0]] <= extMonData;
      monCount <= monCount + 1;
    end
  end

  always @(posedge busClk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog expired after %0d cycles (expected completion)", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge busClk);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge busClk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge busClk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge busClk);
    busRd = 1'b1; busAddr = a;
    @(negedge busClk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic readRx(output logic [31:0] d);
    logic [31:0] s;
    for (int k = 0; k < 400; k++) begin
      busRead(4'h4, s);
      if (!s[3]) break;
    end
    busRead(4'hC, d);
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRead(4'h4, d); check("R1 state after reset", d, 32'h0A);
    busRead(4'h0, d); check("R1 control after reset", d, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    busRead(4'h8, d); check("R2 TX data reads zero", d, 32'h0);
  endtask

  task automatic testRxEmptyRead();
    logic [31:0] d;
    busRead(4'hC, d); check("R6 empty RX read value", d, 32'h0);
    busRead(4'h4, d); check("R6 state unchanged by empty read", d, 32'h0A);
  endtask

  task automatic testDisabledHold();
    logic [31:0] d;
    int base = monCount;
    for (int i = 0; i < 3; i++) busWrite(4'h8, 32'h5500_0000 + i);
    idle(40);
    check("R4 no monitor traffic while disabled", monCount - base, 0);
    busRead(4'h4, d); check("R4 TX queued, RX empty", d, 32'h08);
    busWrite(4'h0, 32'h02);
    idle(10);
    busRead(4'h4, d); check("R7 TX flush empties TX", d, 32'h0A);
    busRead(4'h0, d); check("R7 flush bit reads zero", d, 32'h0);
  endtask

  task automatic testLoopback();
    logic [31:0] d;
    int base = monCount;
    busWrite(4'h0, 32'h01);
    for (int i = 0; i < 5; i++) busWrite(4'h8, 32'h1000_0000 + i * 32'h111);
    idle(60);
    for (int i = 0; i < 5; i++) begin
      readRx(d); check("R3 loopback order", d, 32'h1000_0000 + i * 32'h111);
    end
    check("R3 monitor count", monCount - base, 5);
    for (int i = 0; i < 5; i++)
      check("R3 monitor word", monLog[base + i], 32'h1000_0000 + i * 32'h111);
    busRead(4'h0, d); check("R2 control readback", d, 32'h01);
  endtask

  task automatic testBackpressure();
    logic [31:0] d;
    int base = monCount;
    int errs = 0;
    for (int i = 0; i < 300; i++) busWrite(4'h8, 32'hB000_0000 + i);
    idle(300);
    busRead(4'h4, d); check("R9 RX full, TX holding", d, 32'h04);
    for (int i = 0; i < 300; i++) begin
      readRx(d);
      if (d !== 32'hB000_0000 + i) begin
        errs++;
        check("R9 drained word", d, 32'hB000_0000 + i);
      end
    end
    check("R9 all drained words in order", errs, 0);
    idle(40);
    check("R9 monitor saw every word", monCount - base, 300);
    busRead(4'h4, d); check("R9 both FIFOs empty, no overflow", d, 32'h0A);
  endtask

  task automatic testOverflow();
    logic [31:0] d;
    int base;
    busWrite(4'h0, 32'h00);
    idle(20);
    base = monCount;
    for (int i = 0; i < 256; i++) busWrite(4'h8, 32'hA500_0000 + i);
    busRead(4'h4, d); check("R5 TX full at 256", d, 32'h09);
    busWrite(4'h8, 32'hDEAD_BEEF);
    busRead(4'h4, d); check("R5 overflow set by dropped write", d, 32'h19);
    busWrite(4'h4, 32'h0);
    busRead(4'h4, d); check("R5 overflow stays on write of 0", d, 32'h19);
    busWrite(4'h4, 32'h10);
    busRead(4'h4, d); check("R5 overflow cleared by write of 1", d, 32'h09);
    busWrite(4'h0, 32'h01);
    for (int i = 0; i < 256; i++) begin
      readRx(d);
      if (i == 0 || i == 255) check("R5 kept word", d, 32'hA500_0000 + i);
    end
    idle(50);
    busRead(4'hC, d); check("R5 dropped word absent", d, 32'h0);
    check("R5 monitor count excludes drop", monCount - base, 256);
  endtask

  task automatic testRxFlush();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) busWrite(4'h8, 32'hC000_0000 + i);
    idle(40);
    busWrite(4'h0, 32'h00);
    idle(20);
    busRead(4'h4, d); check("R7 RX holds words before flush", d, 32'h02);
    busWrite(4'h0, 32'h04);
    idle(5);
    busRead(4'h4, d); check("R7 RX flush empties RX", d, 32'h0A);
    busRead(4'hC, d); check("R7 RX read after flush", d, 32'h0);
  endtask

  task automatic testIrq();
    logic [31:0] d;
    busWrite(4'h0, 32'h10);
    idle(3);
    check("R8 irq with TX empty and half mask", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 128; i++) busWrite(4'h8, i);
    idle(3);
    check("R8 irq at 128 words", {31'b0, irq}, 32'h1);
    busWrite(4'h8, 32'h80);
    idle(3);
    check("R8 irq low at 129 words", {31'b0, irq}, 32'h0);
    busWrite(4'h0, 32'h12);
    idle(3);
    check("R8 irq after TX flush", {31'b0, irq}, 32'h1);
    busWrite(4'h0, 32'h09);
    idle(3);
    check("R8 irq low with RX empty", {31'b0, irq}, 32'h0);
    busWrite(4'h8, 32'h7777_0001);
    idle(40);
    check("R8 irq on RX not empty", {31'b0, irq}, 32'h1);
    readRx(d); check("R8 word under irq", d, 32'h7777_0001);
    idle(3);
    check("R8 irq drops after RX drained", {31'b0, irq}, 32'h0);
    busWrite(4'h0, 32'h00);
  endtask

  initial begin
    idle(5);
    busRstN = 1'b1;
    extRstN = 1'b1;
    idle(2);
    testReset();
    testRxEmptyRead();
    testDisabledHold();
    testLoopback();
    testBackpressure();
    testOverflow();
    testRxFlush();
    testIrq();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule